// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator

This block generates four pulse-width modulated outputs from the peripheral clock. Software sets it up through a small word-addressed register port. The two lower channels share one 8-bit prescaler, and the two upper channels share a second one. Each channel then applies its own power-of-two clock divider, selected by a 3-bit code. The result is the channel's count tick.

Each channel runs a 16-bit down-counter. The counter loads the channel's period value when the channel is enabled. The output is high while the count is at or below the channel's compare value, so a compare at or above the period keeps the output high for the whole period. A period of zero stops the channel. An inversion bit complements the waveform while the channel runs. A mode bit selects one of two behaviours:

- Continuous: the counter reloads when it passes zero.
- One-shot: the counter makes a single count-down and then returns to idle.

New period and compare values are captured only at a load or a reload.

Top module: `pwm4_top`

## Requirements
- R1: After reset every register reads zero and all four outputs are low.
- R2: Register addresses and fields read back unchanged:
  - Address 0 (prescalers): bits 7:0 for channels 0 and 1, bits 15:8 for channels 2 and 3.
  - Address 1 (divider selectors): 3 bits per channel at bit 4*ch.
  - Address 2 (control): 4 bits per channel at bit offsets 0, 8, 12 and 16. Within a field, bit 0 is enable, bit 1 is a spare stored bit, bit 2 is invert and bit 3 is continuous mode.
  - Addresses 3+ch: 16-bit period.
  - Addresses 7+ch: 16-bit compare.
  - Unused bits read zero.
- R3: In continuous mode the output repeats every (prescaler+1) × divider × (period+1) clock cycles, with one rising edge per repetition.
- R4: The high time per repetition is (prescaler+1) × divider × (compare+1) cycles when compare is below period.
- R5: When compare is greater than or equal to period, a running non-inverted channel stays high continuously.
- R6: An enabled channel whose period is zero keeps its output low.
- R7: With the invert bit set, the high time of a running channel becomes the full repetition minus the non-inverted high time.
- R8: In one-shot mode a channel counts down from period to zero once, drives (compare+1) × divider × (prescaler+1) high cycles, and then stays low.
- R9: Divider codes map as follows: 0 → 2, 1 → 4, 2 → 8, 3 → 16, 4 → 1. Codes 5 to 7 also give 1.
- R10: Channels 0 and 1 take their prescaler from address 0 bits 7:0, and channels 2 and 3 take theirs from bits 15:8.
- R11: A period or compare value written while a channel runs is applied only at the next reload. Until that reload the old waveform continues.
- R12: Clearing a channel's enable bit drives its output low one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 4 | Channel outputs |

## Verification
The hardest situation to reach from the ports is a value change that lands between two reloads. The bench must show that the old period is still in force and that the new one takes hold only at the reload.

To get there, the bench sets the prescaler and divider to one clock per count and enables a channel whose compare keeps it high. It then writes a zero period two cycles after the load. At that point the counter position is known exactly, so the output must stay high for the rest of the running pass and then fall for good once the zero period is picked up. The one-shot pass is measured the same way, starting from the cycle of the enable write.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
  localparam int NCH    = 4;
  localparam int CNT_W  = 16;
  localparam int PRE_W  = 8;
  localparam int SEL_W  = 3;
  localparam int CTL_W  = 4;
  localparam int DIV_W  = 5;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int NPAIR  = NCH / 2;

  localparam int A_PRE  = 0;
  localparam int A_SEL  = 1;
  localparam int A_CTL  = 2;
  localparam int A_PER  = 3;
  localparam int A_CMP  = A_PER + NCH;

  localparam int B_EN   = 0;
  localparam int B_INV  = 2;
  localparam int B_CONT = 3;

  // divider code -> number of prescaled ticks per count tick
  function automatic logic [DIV_W-1:0] sel_divisor(input logic [SEL_W-1:0] code);
    case (code)
      3'd0:    return DIV_W'(2);
      3'd1:    return DIV_W'(4);
      3'd2:    return DIV_W'(8);
      3'd3:    return DIV_W'(16);
      default: return DIV_W'(1);
    endcase
  endfunction

  // bit offset of a channel's control field in the control word
  function automatic int ctl_offset(input int ch);
    return (ch == 0) ? 0 : 4 + 4 * ch;
  endfunction

  function automatic int sel_offset(input int ch);
    return 4 * ch;
  endfunction
endpackage

// File: rtl/pwm4_regs.sv
module pwm4_regs
  import pwm4_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata,
  output logic [NPAIR-1:0][PRE_W-1:0]   pre,
  output logic [NCH-1:0][SEL_W-1:0]     sel,
  output logic [NCH-1:0][CTL_W-1:0]     ctl,
  output logic [NCH-1:0][CNT_W-1:0]     period,
  output logic [NCH-1:0][CNT_W-1:0]     compare
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre <= '0; sel <= '0; ctl <= '0; period <= '0; compare <= '0;
    end else if (wr) begin
      if (addr == ADDR_W'(A_PRE))
        for (int p = 0; p < NPAIR; p++) pre[p] <= wdata[PRE_W*p +: PRE_W];
      if (addr == ADDR_W'(A_SEL))
        for (int c = 0; c < NCH; c++) sel[c] <= wdata[sel_offset(c) +: SEL_W];
      if (addr == ADDR_W'(A_CTL))
        for (int c = 0; c < NCH; c++) ctl[c] <= wdata[ctl_offset(c) +: CTL_W];
      for (int c = 0; c < NCH; c++) begin
        if (addr == ADDR_W'(A_PER + c)) period[c]  <= wdata[CNT_W-1:0];
        if (addr == ADDR_W'(A_CMP + c)) compare[c] <= wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(A_PRE))
      for (int p = 0; p < NPAIR; p++) rdata[PRE_W*p +: PRE_W] = pre[p];
    if (addr == ADDR_W'(A_SEL))
      for (int c = 0; c < NCH; c++) rdata[sel_offset(c) +: SEL_W] = sel[c];
    if (addr == ADDR_W'(A_CTL))
      for (int c = 0; c < NCH; c++) rdata[ctl_offset(c) +: CTL_W] = ctl[c];
    for (int c = 0; c < NCH; c++) begin
      if (addr == ADDR_W'(A_PER + c)) rdata[CNT_W-1:0] = period[c];
      if (addr == ADDR_W'(A_CMP + c)) rdata[CNT_W-1:0] = compare[c];
    end
  end
endmodule

// File: rtl/pwm4_prescale.sv
module pwm4_prescale #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ratio,
  output logic         tick
);
  logic [W-1:0] cnt;

  assign tick = (cnt >= ratio);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  AST_PRE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ratio != '0) |=> (!tick || ratio == '0)); // R10
endmodule

// File: rtl/pwm4_channel.sv
module pwm4_channel
  import pwm4_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_tick,
  input  logic [SEL_W-1:0] sel,
  input  logic [CTL_W-1:0] ctl,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] compare,
  output logic             pwm_o
);
  logic             en, inv, cont, en_d, running;
  logic [DIV_W-1:0] div_cnt, div_lim;
  logic [CNT_W-1:0] cnt, per_l, cmp_l;
  logic             ch_tick, load_evt, wrap_evt, raw_hi;

  assign en       = ctl[B_EN];
  assign inv      = ctl[B_INV];
  assign cont     = ctl[B_CONT];
  assign div_lim  = sel_divisor(sel) - 1'b1;
  assign ch_tick  = pre_tick && (div_cnt >= div_lim);
  assign load_evt = en && !en_d;
  assign wrap_evt = running && ch_tick && (cnt == '0);
  assign raw_hi   = running && (cnt <= cmp_l);
  assign pwm_o    = running && (raw_hi ^ inv);

  always_ff @(posedge clk) begin
    if (!rst_n)        div_cnt <= '0;
    else if (!en)      div_cnt <= '0;
    else if (pre_tick) div_cnt <= ch_tick ? '0 : div_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_d <= 1'b0; running <= 1'b0; cnt <= '0; per_l <= '0; cmp_l <= '0;
    end else begin
      en_d <= en;
      if (!en) begin
        running <= 1'b0;
        cnt     <= '0;
      end else if (load_evt || (wrap_evt && cont)) begin
        per_l   <= period;
        cmp_l   <= compare;
        cnt     <= period;
        running <= (period != '0);
      end else if (wrap_evt) begin
        running <= 1'b0;
      end else if (running && ch_tick) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt <= per_l)); // R3
  AST_ONESHOT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !cont && en) |=> !running); // R8
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && period != '0) |=> (running && cnt == per_l)); // R11
  AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cmp_l >= per_l && !inv) |-> pwm_o); // R5
endmodule

// File: rtl/pwm4_top.sv
module pwm4_top
  import pwm4_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  logic [NPAIR-1:0][PRE_W-1:0] pre;
  logic [NCH-1:0][SEL_W-1:0]   sel;
  logic [NCH-1:0][CTL_W-1:0]   ctl;
  logic [NCH-1:0][CNT_W-1:0]   period, compare;
  logic [NPAIR-1:0]            pre_tick;

  pwm4_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .pre(pre), .sel(sel), .ctl(ctl),
    .period(period), .compare(compare)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    pwm4_prescale #(.W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .ratio(pre[p]), .tick(pre_tick[p])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm4_channel u_ch (
      .clk(clk), .rst_n(rst_n), .pre_tick(pre_tick[c/2]), .sel(sel[c]),
      .ctl(ctl[c]), .period(period[c]), .compare(compare[c]), .pwm_o(pwm_out[c])
    );

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl[c][B_EN] |=> !pwm_out[c]); // R12
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (pwm_out == '0)); // R1
endmodule

// File: tb/pwm4_top_test.sv
module pwm4_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pwm4_top uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  function automatic int divisor(input int code);
    if (code < 4) return 2 << code;
    return 1;
  endfunction

  task automatic check(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 4'(a);
    #1 d = bus_rdata;
  endtask

  task automatic measure(input int ch, input int warm, input int win,
                         output int hi, output int rises);
    logic prev;
    hi = 0; rises = 0;
    repeat (warm) @(negedge clk);
    prev = pwm_out[ch];
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (pwm_out[ch]) hi++;
      if (pwm_out[ch] && !prev) rises++;
      prev = pwm_out[ch];
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 11; a++) begin
      rd(a, d);
      check($sformatf("R1 reg %0d", a), d, 0);
    end
    check("R1 outputs", pwm_out, 0);
  endtask

  task automatic t_readback;
    logic [31:0] d;
    logic [31:0] mask [11];
    mask[0] = 32'h0000_FFFF; mask[1] = 32'h0000_7777; mask[2] = 32'h000F_FF0F;
    for (int a = 3; a < 11; a++) mask[a] = 32'h0000_FFFF;
    for (int a = 0; a < 11; a++) begin
      wr(a, 32'hFFFF_FFFF);
      rd(a, d);
      check($sformatf("R2 all-ones addr %0d", a), d, mask[a]);
      wr(a, 32'h1234_5A5A);
      rd(a, d);
      check($sformatf("R2 pattern addr %0d", a), d, 32'h1234_5A5A & mask[a]);
    end
    for (int a = 0; a < 11; a++) wr(a, 32'h0);
  endtask

  task automatic t_continuous;
    int hi, rises;
    wr(0, 32'h0000_0301);      // pairs: low=1, high=3
    wr(1, 32'h0000_2340);      // ch0 code0, ch1 code4, ch2 code3, ch3 code2
    wr(3, 4); wr(4, 3); wr(5, 1); wr(6, 2);
    wr(7, 1); wr(8, 0); wr(9, 0); wr(10, 5);
    wr(2, 32'h0009_9909);      // all enabled, continuous
    measure(0, 400, 60, hi, rises);
    check("R3 ch0 edges", rises, 60 / (2 * divisor(0) * 5));
    check("R4 ch0 high", hi, 3 * 2 * divisor(0) * 2);
    measure(1, 10, 64, hi, rises);
    check("R9 R10 ch1 code4 edges", rises, 64 / (2 * divisor(4) * 4));
    check("R4 ch1 high", hi, 8 * 2 * divisor(4) * 1);
    measure(2, 10, 256, hi, rises);
    check("R10 ch2 high pair prescaler edges", rises, 256 / (4 * divisor(3) * 2));
    check("R4 ch2 high", hi, 2 * 4 * divisor(3) * 1);
    measure(3, 10, 50, hi, rises);
    check("R5 ch3 always high", hi, 50);
    check("R5 ch3 no edges", rises, 0);
  endtask

  task automatic t_invert;
    int hi, rises;
    wr(2, 32'h0009_990D);      // ch0 invert
    measure(0, 40, 60, hi, rises);
    check("R7 ch0 inverted high", hi, 60 - 24);
    check("R7 ch0 inverted edges", rises, 3);
    wr(2, 32'h0009_9909);
  endtask

  task automatic t_zero_period;
    int hi, rises;
    wr(4, 0);                  // ch1 period 0
    measure(1, 40, 64, hi, rises);
    check("R6 ch1 zero period", hi, 0);
  endtask

  task automatic t_selector;
    int hi, rises;
    wr(1, 32'h0000_2341);      // ch0 code1
    measure(0, 200, 80, hi, rises);
    check("R9 code1 edges", rises, 80 / (2 * divisor(1) * 5));
    check("R9 code1 high", hi, 2 * 2 * divisor(1) * 2);
  endtask

  task automatic t_disable;
    wr(2, 32'h0);
    @(negedge clk);
    check("R12 ch3 low after disable", pwm_out[3], 0);
    check("R12 all low", pwm_out, 0);
  endtask

  task automatic t_reload;
    int hi, rises;
    wr(0, 32'h0000_0300);
    wr(1, 32'h0000_2344);      // ch0 code4
    wr(3, 9); wr(7, 9);
    wr(2, 32'h0000_0009);
    wr(3, 0);                  // new period 0 during run
    check("R11 old period still in force", pwm_out[0], 1);
    measure(0, 0, 5, hi, rises);
    check("R11 high until reload", hi, 5);
    measure(0, 20, 30, hi, rises);
    check("R11 stopped after reload", hi, 0);
  endtask

  task automatic t_oneshot;
    int hi, rises;
    wr(2, 32'h0);
    wr(3, 3); wr(7, 1);
    wr(2, 32'h0000_0001);      // ch0 enabled, one-shot
    measure(0, 0, 60, hi, rises);
    check("R8 one-shot high cycles", hi, 2 * divisor(4) * 1);
    check("R8 one-shot single pulse", rises, 1);
    measure(0, 0, 40, hi, rises);
    check("R8 stays low", hi, 0);
  endtask

  initial begin
    #1000000;
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_readback();
    t_continuous();
    t_invert();
    t_zero_period();
    t_selector();
    t_disable();
    t_reload();
    t_oneshot();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule